// File: doc/BRIEF.md
# ISA wait-state controller

This block times the command phase of ISA-side bus cycles started by a host-to-ISA bridge. A cycle request arrives with its attributes: I/O or memory space, 8-bit or 16-bit width, whether it is a DMA transfer, whether that DMA transfer is a compatible I/O-to-memory move, and whether it is a refresh. The block then holds the command strobe for a nominal number of bus clocks. It stretches the command while the addressed slave holds the ready line low. It cuts the command short when the slave signals zero-wait and the cycle type allows this. At the end it pulses a cycle-complete flag for one clock.

A second, independent machine serves cycles from an external ISA master that hit the bridge's own registers or main memory. It pulls the ready line low from the clock after such a hit until the internal access reports completion. The block never drives the zero-wait line.

The cycle machine has three states. CS_IDLE goes to CS_CMD on a request. CS_CMD stays in CS_CMD while counting or waiting, and goes to CS_END when the command ends. CS_END always returns to CS_IDLE. The ready machine has two states. RS_FREE goes to RS_HOLD on a hit strobe, and RS_HOLD goes back to RS_FREE on the done strobe.

Top module: `isa_wait_ctrl`

## Requirements
- R1: While reset is asserted, and in the first clock after it, `cmd_active`, `cyc_done` and `rdy_drive_low` are all 0.
- R2: A `cyc_req` sampled high in CS_IDLE raises `cmd_active` from the next clock. With no wait and no shortening, the command lasts 4 clocks for 8-bit cycles (`cyc_wide`=0) and 2 clocks for 16-bit cycles (`cyc_wide`=1). A `cyc_req` is ignored outside CS_IDLE.
- R3: For refresh cycles and for non-DMA cycles, `iochrdy_in`=0 sampled in the last nominal command clock, or in any later one, keeps the command active for one more clock. There is no limit on the number of wait clocks.
- R4: For DMA cycles (`cyc_dma`=1, `cyc_refresh`=0), `iochrdy_in` is honoured only when `dma_compat`=1. Otherwise the command keeps its nominal length.
- R5: `zerows_n_in`=0 sampled in any command clock ends the command at that edge when the cycle is not DMA and not refresh, and targets memory of either width (`cyc_io`=0) or 8-bit I/O.
- R6: `zerows_n_in` has no effect on 16-bit I/O cycles, on DMA cycles or on refresh cycles.
- R7: When `iochrdy_in`=0 is honoured in a clock, it takes precedence over `zerows_n_in`=0 in that same clock. The command is not ended there, and the count still advances toward the nominal end.
- R8: `cyc_done` is high for exactly one clock: the first clock with `cmd_active` low after a command. The clock after that is CS_IDLE.
- R9: An `ext_hit` strobe sampled while not driving sets `rdy_drive_low` to 1 from the next clock. It stays 1 until the clock after `int_done` is sampled high. `ext_hit` while driving, and `int_done` while not driving, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_req | input | 1 | Start a bridge-side cycle (sampled in idle) |
| cyc_io | input | 1 | 1 = I/O space, 0 = memory space |
| cyc_wide | input | 1 | 1 = 16-bit target, 0 = 8-bit target |
| cyc_dma | input | 1 | Cycle is a DMA transfer |
| dma_compat | input | 1 | DMA transfer is a compatible I/O-to-memory move |
| cyc_refresh | input | 1 | Cycle is a refresh |
| iochrdy_in | input | 1 | Sampled ready line, 0 = slave not ready |
| zerows_n_in | input | 1 | Sampled zero-wait line, 0 = shorten requested |
| ext_hit | input | 1 | Strobe: an external master addresses an internal target |
| int_done | input | 1 | Strobe: the internal access has completed |
| cmd_active | output | 1 | Command strobe timing, high during the command phase |
| cyc_done | output | 1 | One-clock cycle-complete pulse |
| rdy_drive_low | output | 1 | 1 = pull the ready line low, 0 = release (tri-state) |

## Verification
The timing is exercised with plain 8-bit and 16-bit cycles, which separate the two nominal lengths. Ready held low for a short stretch and for a very long one shows that waits are added only from the last nominal clock and have no cap. Zero-wait asserted in the first and in a later command clock, applied to memory, 8-bit I/O, 16-bit I/O, DMA and refresh cycles, separates the cycle types that may be shortened from those that may not. Ready and zero-wait are also asserted together, both early in the count and at its end, to show which one wins and that the count keeps running. The ready drive is tried with redundant hit and done strobes to show that only the proper edges move it.

// File: rtl/isa_wait_pkg.sv
package isa_wait_pkg;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_CMD,
        CS_END
    } cyc_state_t;

    typedef enum logic {
        RS_FREE,
        RS_HOLD
    } rdy_state_t;

    typedef struct packed {
        logic io;
        logic wide;
        logic dma;
        logic compat;
        logic refr;
    } cyc_attr_t;

endpackage

// File: rtl/isa_cyc_qual.sv
module isa_cyc_qual
    import isa_wait_pkg::*;
#(
    parameter int LEN8  = 4,
    parameter int LEN16 = 2,
    parameter int CW    = 3
) (
    input  cyc_attr_t       attr,
    output logic            honour_rdy,
    output logic            allow_short,
    output logic [CW-1:0]   first_cnt
);

    always_comb begin
        // refresh always honours ready; DMA only when compatible
        honour_rdy  = attr.refr | ~attr.dma | attr.compat;
        // shortening: bridge-mastered non-DMA, not 16-bit I/O
        allow_short = ~attr.dma & ~attr.refr & ~(attr.io & attr.wide);
        first_cnt   = attr.wide ? CW'(LEN16 - 1) : CW'(LEN8 - 1);
    end

endmodule

// File: rtl/isa_cmd_fsm.sv
module isa_cmd_fsm
    import isa_wait_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            honour_rdy,
    input  logic            allow_short,
    input  logic [CW-1:0]   first_cnt,
    input  logic            iochrdy,
    input  logic            zerows_n,
    output logic            cmd_active,
    output logic            cyc_done
);

    cyc_state_t     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           hon_q, shr_q;
    logic           rdy_low, zw_low;

    assign rdy_low = hon_q & ~iochrdy;
    assign zw_low  = shr_q & ~zerows_n;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CS_IDLE: begin
                if (req) begin
                    state_d = CS_CMD;
                    cnt_d   = first_cnt;
                end
            end
            CS_CMD: begin
                if (rdy_low) begin
                    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
                end else if (zw_low || cnt_q == '0) begin
                    state_d = CS_END;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            CS_END: state_d = CS_IDLE;
            default: state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
            hon_q   <= 1'b0;
            shr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == CS_IDLE && req) begin
                hon_q <= honour_rdy;
                shr_q <= allow_short;
            end
        end
    end

    always_comb begin
        cmd_active = (state_q == CS_CMD);
        cyc_done   = (state_q == CS_END);
    end

    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_IDLE && req) |=> (state_q == CS_CMD)); // R2
    AST_RDY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_CMD && cnt_q == '0 && hon_q && !iochrdy) |=> (state_q == CS_CMD)); // R3
    AST_DMA_RDY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_CMD && cnt_q == '0 && !hon_q) |=> (state_q == CS_END)); // R4
    AST_SHORTEN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_CMD && shr_q && !zerows_n && (!hon_q || iochrdy)) |=> (state_q == CS_END)); // R5
    AST_SHORTEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_CMD && !shr_q && cnt_q != '0 && (!hon_q || iochrdy)) |=> (state_q == CS_CMD)); // R6
    AST_RDY_OVER_ZW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_CMD && hon_q && !iochrdy) |=> (state_q == CS_CMD)); // R7
    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (!cyc_done && !cmd_active)); // R8
    AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_active) |-> cyc_done); // R8

endmodule

// File: rtl/isa_rdy_hold.sv
module isa_rdy_hold
    import isa_wait_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_hit,
    input  logic int_done,
    output logic drive_low
);

    rdy_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_FREE: if (ext_hit)  st_d = RS_HOLD;
            RS_HOLD: if (int_done) st_d = RS_FREE;
            default: st_d = RS_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RS_FREE;
        else        st_q <= st_d;
    end

    always_comb drive_low = (st_q == RS_HOLD);

    AST_RDY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low && !int_done) |=> drive_low); // R9
    AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low && int_done) |=> !drive_low); // R9
    AST_RDY_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_low && ext_hit) |=> drive_low); // R9

endmodule

// File: rtl/isa_wait_ctrl.sv
module isa_wait_ctrl
    import isa_wait_pkg::*;
#(
    parameter int LEN8  = 4,
    parameter int LEN16 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_req,
    input  logic cyc_io,
    input  logic cyc_wide,
    input  logic cyc_dma,
    input  logic dma_compat,
    input  logic cyc_refresh,
    input  logic iochrdy_in,
    input  logic zerows_n_in,
    input  logic ext_hit,
    input  logic int_done,
    output logic cmd_active,
    output logic cyc_done,
    output logic rdy_drive_low
);

    localparam int LMAX = (LEN8 > LEN16) ? LEN8 : LEN16;
    localparam int CW   = (LMAX > 1) ? $clog2(LMAX) : 1;

    cyc_attr_t      attr;
    logic           honour_rdy, allow_short;
    logic [CW-1:0]  first_cnt;

    always_comb begin
        attr.io     = cyc_io;
        attr.wide   = cyc_wide;
        attr.dma    = cyc_dma;
        attr.compat = dma_compat;
        attr.refr   = cyc_refresh;
    end

    isa_cyc_qual #(.LEN8(LEN8), .LEN16(LEN16), .CW(CW)) u_qual (
        .attr        (attr),
        .honour_rdy  (honour_rdy),
        .allow_short (allow_short),
        .first_cnt   (first_cnt)
    );

    isa_cmd_fsm #(.CW(CW)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (cyc_req),
        .honour_rdy  (honour_rdy),
        .allow_short (allow_short),
        .first_cnt   (first_cnt),
        .iochrdy     (iochrdy_in),
        .zerows_n    (zerows_n_in),
        .cmd_active  (cmd_active),
        .cyc_done    (cyc_done)
    );

    isa_rdy_hold u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_hit   (ext_hit),
        .int_done  (int_done),
        .drive_low (rdy_drive_low)
    );

endmodule

// File: tb/isa_wait_ctrl_bench.sv
`timescale 1ns/1ps
module isa_wait_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_req = 0, cyc_io = 0, cyc_wide = 0, cyc_dma = 0, dma_compat = 0, cyc_refresh = 0;
    logic iochrdy_in = 1, zerows_n_in = 1, ext_hit = 0, int_done = 0;
    logic cmd_active, cyc_done, rdy_drive_low;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    isa_wait_ctrl u_isa_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .cyc_io(cyc_io), .cyc_wide(cyc_wide),
        .cyc_dma(cyc_dma), .dma_compat(dma_compat), .cyc_refresh(cyc_refresh),
        .iochrdy_in(iochrdy_in), .zerows_n_in(zerows_n_in), .ext_hit(ext_hit),
        .int_done(int_done), .cmd_active(cmd_active), .cyc_done(cyc_done),
        .rdy_drive_low(rdy_drive_low)
    );

    // behavioural reference: phase 0 idle, 1 command, 2 complete
    int m_ph = 0, m_left = 0;
    bit m_hon = 0, m_shr = 0, m_drv = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_drv = 0;
        end else begin
            if (m_ph == 0) begin
                if (cyc_req) begin
                    m_ph   = 1;
                    m_left = cyc_wide ? 1 : 3;
                    m_hon  = cyc_refresh || !cyc_dma || dma_compat;
                    m_shr  = !cyc_dma && !cyc_refresh && !(cyc_io && cyc_wide);
                end
            end else if (m_ph == 1) begin
                if (m_hon && !iochrdy_in) begin
                    if (m_left > 0) m_left--;
                end else if ((m_shr && !zerows_n_in) || m_left == 0) begin
                    m_ph = 2;
                end else begin
                    m_left--;
                end
            end else begin
                m_ph = 0;
            end
            if (!m_drv && ext_hit) m_drv = 1;
            else if (m_drv && int_done) m_drv = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cmd_active == (m_ph == 1), cur_tag, "cmd_active vs model", cmd_active, m_ph == 1);
            check(cyc_done == (m_ph == 2), "R8", "cyc_done vs model", cyc_done, m_ph == 2);
            check(rdy_drive_low == m_drv, "R9", "rdy_drive_low vs model", rdy_drive_low, m_drv);
        end
    end

    task automatic run_cyc(input logic io, input logic wide, input logic dma, input logic compat,
                           input logic refr, input int rlow, input int zfrom, input int exp_len,
                           input string tag);
        int len;
        cur_tag = tag;
        @(negedge clk);
        cyc_io = io; cyc_wide = wide; cyc_dma = dma; dma_compat = compat; cyc_refresh = refr;
        cyc_req = 1; iochrdy_in = 1; zerows_n_in = 1;
        @(negedge clk);
        cyc_req = 0;
        len = 0;
        while (cmd_active && len < 1000) begin
            iochrdy_in  = !(len < rlow);
            zerows_n_in = !(zfrom >= 0 && len >= zfrom);
            len++;
            @(negedge clk);
        end
        iochrdy_in = 1; zerows_n_in = 1;
        check(cyc_done == 1'b1, "R8", "done pulse after command", cyc_done, 1);
        check(len == exp_len, tag, "command length", len, exp_len);
        @(negedge clk);
        check(cyc_done == 1'b0, "R8", "done low after one clock", cyc_done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_active == 0, "R1", "cmd_active in reset", cmd_active, 0);
        check(cyc_done == 0, "R1", "cyc_done in reset", cyc_done, 0);
        check(rdy_drive_low == 0, "R1", "rdy_drive_low in reset", rdy_drive_low, 0);
        rst_n = 1;
        @(negedge clk);
        check(cmd_active == 0 && cyc_done == 0 && rdy_drive_low == 0, "R1", "outputs after reset",
              {cmd_active, cyc_done, rdy_drive_low}, 0);

        // R2 nominal lengths
        run_cyc(0, 0, 0, 0, 0, 0, -1, 4, "R2");
        run_cyc(0, 1, 0, 0, 0, 0, -1, 2, "R2");
        // R3 waits, short and long
        run_cyc(1, 0, 0, 0, 0, 6, -1, 7, "R3");
        run_cyc(0, 1, 0, 0, 1, 5, -1, 6, "R3");
        run_cyc(1, 0, 0, 0, 0, 200, -1, 201, "R3");
        // R4 DMA ready gating
        run_cyc(0, 0, 1, 0, 0, 6, -1, 4, "R4");
        run_cyc(0, 0, 1, 1, 0, 6, -1, 7, "R4");
        // R5 shortening
        run_cyc(0, 1, 0, 0, 0, 0, 0, 1, "R5");
        run_cyc(0, 0, 0, 0, 0, 0, 1, 2, "R5");
        run_cyc(1, 0, 0, 0, 0, 0, 0, 1, "R5");
        // R6 zero-wait ignored
        run_cyc(1, 1, 0, 0, 0, 0, 0, 2, "R6");
        run_cyc(0, 0, 1, 1, 0, 0, 0, 4, "R6");
        run_cyc(0, 0, 0, 0, 1, 0, 0, 4, "R6");
        // R7 ready dominates zero-wait
        run_cyc(0, 0, 0, 0, 0, 2, 0, 3, "R7");
        run_cyc(0, 1, 0, 0, 0, 3, 0, 4, "R7");

        // R2 request held high: back-to-back cycles, extra requests ignored mid-cycle
        cur_tag = "R2";
        @(negedge clk);
        cyc_io = 0; cyc_wide = 0; cyc_dma = 0; cyc_refresh = 0; cyc_req = 1;
        repeat (14) @(negedge clk);
        cyc_req = 0;
        repeat (8) @(negedge clk);
        check(cmd_active == 0, "R2", "idle after held request", cmd_active, 0);

        // R9 ready-line drive
        cur_tag = "R9";
        int_done = 1;
        @(negedge clk);
        int_done = 0;
        check(rdy_drive_low == 0, "R9", "done while free ignored", rdy_drive_low, 0);
        ext_hit = 1;
        @(negedge clk);
        ext_hit = 0;
        check(rdy_drive_low == 1, "R9", "drive after hit", rdy_drive_low, 1);
        repeat (2) @(negedge clk);
        ext_hit = 1;
        @(negedge clk);
        ext_hit = 0;
        check(rdy_drive_low == 1, "R9", "hit while driving ignored", rdy_drive_low, 1);
        repeat (3) @(negedge clk);
        check(rdy_drive_low == 1, "R9", "held until done", rdy_drive_low, 1);
        int_done = 1;
        @(negedge clk);
        int_done = 0;
        check(rdy_drive_low == 0, "R9", "release after done", rdy_drive_low, 0);
        repeat (3) @(negedge clk);
        check(rdy_drive_low == 0, "R9", "stays released", rdy_drive_low, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule